// File: doc/BRIEF.md
# Command/Data Port Interrupt Controller

This block gathers up to 128 interrupt lines and reports them to an 8-bit CPU on one active-low request line. Software reaches everything through two byte-wide bus locations. It first writes a command byte to the command location, then reads or writes the data location. The upper three bits of the command pick an operation class. The lower five bits pick a byte register in one of two banks: a mask bank that enables sources, and a trigger-type bank that makes each source edge- or level-sensitive.

Edge sources latch a pending flag on a rising input and keep it until software completes the interrupt. Level sources are pending exactly while their input is high. In the status operation, software reads the data location to get the lowest-numbered enabled pending source. The controller records that number. A later end-of-interrupt command clears the latch of that recorded source only.

Top module: `irq_cmd_ctrl`

## Requirements
- R1: After reset the request output `irq_n` is 1, every mask and type byte reads 0x00, and a status read returns 0xFF.
- R2: A write to address 0 stores the command byte, and a read of address 0 returns it. Command bits 7:5 are the operation: 0 is status, 1 is the mask bank, 2 is the type bank. Bits 4:0 select a byte register. In the mask and type operations, data-port writes store the selected byte and data-port reads return it. Any other operation reads the data port as 0x00.
- R3: Source n is governed by bit (n mod 8) of byte register (n div 8) in both the mask bank and the type bank.
- R4: A byte select at or above NUM_SRC/8 reads as 0x00, and data writes to it change no register (no aliasing onto lower bytes).
- R5: A source whose type bit is 0 latches a pending flag on the clock after its input goes from 0 to 1. The latch forms whether or not the source is enabled. It stays set until an end-of-interrupt names that source, even if the input stays high.
- R6: A source whose type bit is 1 is pending exactly while its input is 1, and needs no end-of-interrupt.
- R7: In the status operation (command 0x00 to 0x1F), a data-port read returns the lowest-numbered source that is both enabled and pending, or 0xFF when there is none.
- R8: `irq_n` is 0 one clock after any enabled source is pending, and 1 one clock after none is.
- R9: A data-port write while the command is 0xFF clears the latch of the source most recently returned by a status read. Other latches are unaffected, so `irq_n` stays 0 while another enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 selects the command port, 1 the data port |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| irq_in | input | NUM_SRC | Interrupt source lines, synchronous to clk |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
Several corner cases are targeted, each with the symptom of a wrong design:
- **Out-of-range byte select.** A design that ignores the top select bit would let a write there land on a lower byte, which would then read back as nonzero.
- **Edge input held high across an end-of-interrupt.** A design that re-latches from the level, instead of from a transition, would keep `irq_n` low forever.
- **Two edge sources pending at once.** These catch a completion that clears every latch, and a priority encoder that favours the highest number.
- **Latch forming while the source is masked.** A design that gates the latch with the mask would lose the interrupt when the mask opens.
- **Random masks over random level inputs.** These exercise the lowest-number search across all sixteen bytes.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam logic [2:0] OP_STATUS = 3'd0;
  localparam logic [2:0] OP_MASK   = 3'd1;
  localparam logic [2:0] OP_TYPE   = 3'd2;
  localparam logic [7:0] CMD_DONE  = 8'hFF;
  localparam logic [7:0] ID_NONE   = 8'hFF;
  localparam int         SEL_W     = 5;
endpackage

// File: rtl/ictl_bank.sv
module ictl_bank #(
  parameter int NBYTES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ictl_pkg::SEL_W-1:0]   sel,
  input  logic [7:0]                   wdata,
  output logic [7:0]                   rd_byte,
  output logic [NBYTES*8-1:0]          bits
);
  localparam int SW = ictl_pkg::SEL_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [7:0] byte_q;
    logic [7:0] byte_d;
    logic       byte_en;

    assign byte_en = wr_en && (sel == SW'(b));

    always_comb begin
      byte_d = byte_q;
      if (byte_en) byte_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= 8'h00;
      else if (byte_en) byte_q <= byte_d;
    end

    assign bits[b*8 +: 8] = byte_q;
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int b = 0; b < NBYTES; b++) begin
      if (sel == SW'(b)) rd_byte = bits[b*8 +: 8];
    end
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bits)); // R2
  AST_BANK_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(sel) >= NBYTES)) |=> $stable(bits)); // R4
endmodule

// File: rtl/ictl_pend.sv
module ictl_pend #(
  parameter int N = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] typ,
  input  logic         eoi,
  input  logic [7:0]   eoi_id,
  output logic [N-1:0] pend
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] prev_q;
  logic [N-1:0] latch_q;
  logic [N-1:0] latch_d;
  logic [N-1:0] set_v;
  logic [N-1:0] clr_v;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign set_v[i]   = src_in[i] & ~prev_q[i] & ~typ[i];
    assign clr_v[i]   = eoi && (eoi_id == 8'(i));
    assign latch_d[i] = set_v[i] | (latch_q[i] & ~clr_v[i]);
    assign pend[i]    = typ[i] ? src_in[i] : latch_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= src_in;
      latch_q <= latch_d;
    end
  end

  AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & $past(set_v)) == $past(set_v))); // R5
  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi |=> (($past(latch_q) & ~latch_q) == '0)); // R5
  AST_EOI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && (int'(eoi_id) < N) && !set_v[eoi_id[IW-1:0]])
      |=> !latch_q[$past(eoi_id[IW-1:0])]); // R9
endmodule

// File: rtl/ictl_prio.sv
module ictl_prio #(
  parameter int N = 128
) (
  input  logic [N-1:0] act,
  output logic         valid,
  output logic [7:0]   id
);
  always_comb begin
    valid = 1'b0;
    id    = ictl_pkg::ID_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) begin
        valid = 1'b1;
        id    = 8'(i);
      end
    end
  end
endmodule

// File: rtl/irq_cmd_ctrl.sv
module irq_cmd_ctrl #(
  parameter int NUM_SRC = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               irq_n
);
  import ictl_pkg::*;

  localparam int NBYTES = NUM_SRC / 8;
  localparam int IW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [7:0]         cmd_q, cmd_d;
  logic [7:0]         last_q, last_d;
  logic               irq_n_q, irq_n_d;
  logic [2:0]         op;
  logic [SEL_W-1:0]   sel;
  logic               is_done;
  logic               dat_wr, cmd_wr, stat_rd;
  logic               mask_wr, type_wr, eoi;
  logic [7:0]         mask_rd, type_rd;
  logic [NUM_SRC-1:0] mask_bits, type_bits, pend, act;
  logic               prio_valid;
  logic [7:0]         prio_id;

  assign op      = cmd_q[7:5];
  assign sel     = cmd_q[SEL_W-1:0];
  assign is_done = (cmd_q == CMD_DONE);
  assign cmd_wr  = bus_wr && !bus_addr;
  assign dat_wr  = bus_wr && bus_addr;
  assign mask_wr = dat_wr && !is_done && (op == OP_MASK);
  assign type_wr = dat_wr && !is_done && (op == OP_TYPE);
  assign eoi     = dat_wr && is_done;
  assign stat_rd = bus_rd && bus_addr && (op == OP_STATUS);

  ictl_bank #(.NBYTES(NBYTES)) i_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr), .sel(sel),
    .wdata(bus_wdata), .rd_byte(mask_rd), .bits(mask_bits)
  );

  ictl_bank #(.NBYTES(NBYTES)) i_type (
    .clk(clk), .rst_n(rst_n), .wr_en(type_wr), .sel(sel),
    .wdata(bus_wdata), .rd_byte(type_rd), .bits(type_bits)
  );

  ictl_pend #(.N(NUM_SRC)) i_pend (
    .clk(clk), .rst_n(rst_n), .src_in(irq_in), .typ(type_bits),
    .eoi(eoi), .eoi_id(last_q), .pend(pend)
  );

  assign act = pend & mask_bits;

  ictl_prio #(.N(NUM_SRC)) i_prio (
    .act(act), .valid(prio_valid), .id(prio_id)
  );

  always_comb begin
    cmd_d   = cmd_q;
    last_d  = last_q;
    irq_n_d = ~(|act);
    if (cmd_wr) cmd_d = bus_wdata;
    if (stat_rd && prio_valid) last_d = prio_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= 8'h00;
      last_q  <= ID_NONE;
      irq_n_q <= 1'b1;
    end else begin
      if (cmd_wr) cmd_q <= cmd_d;
      if (stat_rd && prio_valid) last_q <= last_d;
      irq_n_q <= irq_n_d;
    end
  end

  assign irq_n = irq_n_q;

  always_comb begin
    bus_rdata = 8'h00;
    if (!bus_addr) begin
      bus_rdata = cmd_q;
    end else if (!is_done) begin
      case (op)
        OP_STATUS: bus_rdata = prio_id;
        OP_MASK:   bus_rdata = mask_rd;
        OP_TYPE:   bus_rdata = type_rd;
        default:   bus_rdata = 8'h00;
      endcase
    end
  end

  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_n == !$past(|act))); // R8
  AST_PRIO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    prio_valid |-> act[prio_id[IW-1:0]]); // R7
  AST_PRIO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    prio_valid |-> ((act & ((NUM_SRC'(1) << prio_id[IW-1:0]) - NUM_SRC'(1))) == '0)); // R7
  AST_PRIO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_valid |-> ((prio_id == ID_NONE) && (act == '0))); // R7
endmodule

// File: tb/test_irq_cmd_ctrl.sv
module test_irq_cmd_ctrl;
  localparam int N  = 128;
  localparam int NB = N / 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_addr, bus_wr, bus_rd;
  logic [7:0]   bus_wdata;
  logic [7:0]   bus_rdata;
  logic [N-1:0] irq_in;
  logic         irq_n;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  logic [N-1:0] m_mask;
  logic [7:0]   v;

  irq_cmd_ctrl #(.NUM_SRC(N)) i_irq_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_n(irq_n)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nerr = nerr + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  function automatic logic [7:0] lowest(input logic [N-1:0] vec);
    lowest = 8'hFF;
    for (int i = N - 1; i >= 0; i--) if (vec[i]) lowest = 8'(i);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nerr = nerr + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic get(output logic [7:0] d);
    bus_addr = 1'b1; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_sel(input logic [7:0] c, output logic [7:0] d);
    put(1'b0, c);
    get(d);
  endtask

  task automatic eoi_cmd();
    put(1'b0, 8'hFF);
    put(1'b1, 8'h01);
  endtask

  task automatic pulse(input int s);
    irq_in[s] = 1'b1;
    @(negedge clk);
    irq_in[s] = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; bus_addr = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = 8'h00; irq_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    rd_sel(8'h00, v); chk("R1 status", v, 8'hFF);
    rd_sel(8'h25, v); chk("R1 mask byte", v, 8'h00);
    rd_sel(8'h4F, v); chk("R1 type byte", v, 8'h00);

    // R2 readback, command readback, unused op
    put(1'b0, 8'h23); put(1'b1, 8'h5A);
    get(v); chk("R2 mask readback", v, 8'h5A);
    put(1'b0, 8'h4E); put(1'b1, 8'hC3);
    get(v); chk("R2 type readback", v, 8'hC3);
    bus_addr = 1'b0; bus_rd = 1'b1; #1 v = bus_rdata; bus_rd = 1'b0;
    chk("R2 command readback", v, 8'h4E);
    rd_sel(8'h23, v); chk("R2 bank separate", v, 8'h5A);
    rd_sel(8'h63, v); chk("R2 unused op", v, 8'h00);
    put(1'b0, 8'h23); put(1'b1, 8'h00);
    put(1'b0, 8'h4E); put(1'b1, 8'h00);

    // R4 out-of-range select
    put(1'b0, 8'h34); put(1'b1, 8'hAA);
    get(v); chk("R4 oor read", v, 8'h00);
    rd_sel(8'h24, v); chk("R4 no alias", v, 8'h00);
    put(1'b0, 8'h5F); put(1'b1, 8'hFF);
    rd_sel(8'h4F, v); chk("R4 no alias type", v, 8'h00);

    // R3 R5 R8 R9 edge source 9 (byte 1 bit 1)
    put(1'b0, 8'h21); put(1'b1, 8'h02);
    pulse(9); idle(2);
    chk("R8 irq asserted", {7'd0, irq_n}, 8'h00);
    rd_sel(8'h00, v); chk("R3 R7 id 9", v, 8'd9);
    eoi_cmd(); idle(2);
    chk("R9 irq released", {7'd0, irq_n}, 8'h01);
    rd_sel(8'h00, v); chk("R9 none left", v, 8'hFF);

    // R5 input held high across EOI: no re-latch
    irq_in[9] = 1'b1; idle(2);
    rd_sel(8'h00, v); chk("R5 held edge", v, 8'd9);
    eoi_cmd(); idle(2);
    chk("R5 no relatch", {7'd0, irq_n}, 8'h01);
    irq_in[9] = 1'b0;
    put(1'b0, 8'h21); put(1'b1, 8'h00);

    // R9 two sources 3 and 40
    put(1'b0, 8'h20); put(1'b1, 8'h08);
    put(1'b0, 8'h25); put(1'b1, 8'h01);
    irq_in[3] = 1'b1; irq_in[40] = 1'b1; @(negedge clk);
    irq_in[3] = 1'b0; irq_in[40] = 1'b0; idle(2);
    rd_sel(8'h00, v); chk("R7 lowest 3", v, 8'd3);
    eoi_cmd(); idle(2);
    chk("R9 still asserted", {7'd0, irq_n}, 8'h00);
    rd_sel(8'h00, v); chk("R9 next 40", v, 8'd40);
    eoi_cmd(); idle(2);
    chk("R9 all done", {7'd0, irq_n}, 8'h01);
    put(1'b0, 8'h20); put(1'b1, 8'h00);
    put(1'b0, 8'h25); put(1'b1, 8'h00);

    // R5 latch forms while masked (source 17)
    pulse(17); idle(2);
    chk("R8 masked quiet", {7'd0, irq_n}, 8'h01);
    rd_sel(8'h00, v); chk("R5 masked status", v, 8'hFF);
    put(1'b0, 8'h22); put(1'b1, 8'h02); idle(2);
    chk("R5 unmask fires", {7'd0, irq_n}, 8'h00);
    rd_sel(8'h00, v); chk("R5 id 17", v, 8'd17);
    eoi_cmd(); idle(2);
    chk("R9 17 done", {7'd0, irq_n}, 8'h01);
    put(1'b0, 8'h22); put(1'b1, 8'h00);

    // R6 level source 10
    put(1'b0, 8'h41); put(1'b1, 8'h04);
    put(1'b0, 8'h21); put(1'b1, 8'h04);
    irq_in[10] = 1'b1; idle(2);
    chk("R6 level asserted", {7'd0, irq_n}, 8'h00);
    rd_sel(8'h00, v); chk("R6 id 10", v, 8'd10);
    irq_in[10] = 1'b0; idle(2);
    chk("R6 level released", {7'd0, irq_n}, 8'h01);
    rd_sel(8'h00, v); chk("R6 none", v, 8'hFF);

    // R7 R8 R2 random masks over level inputs
    for (int b = 0; b < NB; b++) begin
      put(1'b0, 8'h40 | 8'(b)); put(1'b1, 8'hFF);
    end
    m_mask = '0;
    for (int it = 0; it < 60; it++) begin
      logic [N-1:0] lv;
      int rb;
      for (int b = 0; b < NB; b++) begin
        logic [7:0] mb;
        mb = 8'($urandom);
        m_mask[b*8 +: 8] = mb;
        put(1'b0, 8'h20 | 8'(b)); put(1'b1, mb);
      end
      for (int w = 0; w < N / 32; w++)
        lv[w*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
      if (it % 7 == 0) lv = '0;
      irq_in = lv; idle(2);
      chk("R8 random irq", {7'd0, irq_n}, {7'd0, ~(|(lv & m_mask))});
      rd_sel(8'h00, v); chk("R7 random lowest", v, lowest(lv & m_mask));
      rb = int'($urandom % NB);
      rd_sel(8'h20 | 8'(rb), v); chk("R2 random readback", v, m_mask[rb*8 +: 8]);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule